// File: doc/BRIEF.md
# Vertical Frame Period Meter

This block measures how long each video frame lasts by timing the gap between consecutive rising edges of the vertical sync input. A free-running prescaler divides the system clock by a parameterised factor (16 by default, giving an 8 µs tick at a 2 MHz processor clock). A counter accumulates those ticks across one frame, and on every new sync edge the finished count is captured into a holding register. Firmware then reads that register as a high byte and a low byte and works out the frame rate, roughly 1 / (count × tick period).

The captured count is 13 bits wide and saturates at 0x1FFF, which is about 15.26 Hz with an 8 µs tick. The validity output combines two conditions: the external sync-detect status, and whether at least one complete frame has been measured since reset. The outputs are plain register values that firmware may sample at any time. There is no handshake and no back-pressure, because each new capture simply replaces the old one.

Top module: `frame_period_meter`

## Requirements
- R1: After reset, `period_hi_o`, `period_lo_o` and `period_valid_o` are all zero.
- R2: If N clock cycles separate two rising edges of `vsync_i`, the value captured at the second edge is floor(N / 16) with the default divider.
- R3: The capture reaches the outputs at the third rising clock edge after `vsync_i` is first sampled high. At every other time the outputs keep their value.
- R4: `period_lo_o` carries count bits 7..0 and `period_hi_o` bits 4..0 carry count bits 12..8. `period_hi_o` bits 7..5 always read zero. Both bytes always come from the same capture.
- R5: A frame longer than 0x1FFF ticks is captured as 0x1FFF. The running count does not wrap.
- R6: `period_valid_o` is high only when `vdet_i` is high and at least two sync rising edges have been seen since reset. It is low whenever `vdet_i` is low.
- R7: Only a low-to-high transition of `vsync_i` starts a new frame. How long the pulse stays high, whether one cycle or nearly the whole frame, has no effect on the captured count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_i | input | 1 | Vertical sync, asynchronous, active high |
| vdet_i | input | 1 | Sync-detect status from the polarity/presence logic |
| period_hi_o | output | 8 | Captured count bits 12..8 in bits 4..0, zeros above |
| period_lo_o | output | 8 | Captured count bits 7..0 |
| period_valid_o | output | 1 | Captured count may be trusted |

## Verification
Several properties are checked on every cycle by assertions:
- a detected sync edge lasts exactly one cycle;
- the prescaler tick never fires on two cycles in a row;
- the running count stays pinned once it reaches 0x1FFF;
- the holding register changes only on a sync edge;
- the unused high bits stay zero;
- validity is never raised while `vdet_i` is low.

Other behaviour can only be shown by the bench's scenarios. These are the exact floor-division result for a given frame length, the three-cycle capture latency, independence from pulse width, and the saturated value after a very slow frame.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int DEF_CNT_W   = 13;
  localparam int DEF_DIV     = 16;
  localparam int DEF_SYNC    = 2;
  localparam int BYTE_W      = 8;
  localparam int PAIR_W      = 2 * BYTE_W;
endpackage

// File: rtl/fpm_sync_edge.sv
module fpm_sync_edge #(
  parameter int STAGES = fpm_pkg::DEF_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R7
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/fpm_prescaler.sv
module fpm_prescaler #(
  parameter int DIV = fpm_pkg::DEF_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre_q <= '0;
    else if (clr)   pre_q <= '0;
    else if (tick)  pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R2
  pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tick);
endmodule

// File: rtl/fpm_period_ctr.sv
module fpm_period_ctr #(
  parameter int W = fpm_pkg::DEF_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] lat_o,
  output logic         full_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, lat_q, cnt_nxt;
  logic [1:0]   seen_q;

  always_comb begin
    cnt_nxt = cnt_q;
    if (tick && (cnt_q != TOP)) cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lat_q  <= '0;
      seen_q <= '0;
    end else if (clr) begin
      lat_q  <= cnt_nxt;
      cnt_q  <= '0;
      if (seen_q != 2'd2) seen_q <= seen_q + 1'b1;
    end else begin
      cnt_q  <= cnt_nxt;
    end
  end

  assign lat_o  = lat_q;
  assign full_o = (seen_q == 2'd2);

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP) && !clr |=> (cnt_q == TOP));
  // R3
  lat_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> $stable(lat_q));
  // R2
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/frame_period_meter.sv
module frame_period_meter #(
  parameter int CNT_W       = fpm_pkg::DEF_CNT_W,
  parameter int TICK_DIV    = fpm_pkg::DEF_DIV,
  parameter int SYNC_STAGES = fpm_pkg::DEF_SYNC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vsync_i,
  input  logic       vdet_i,
  output logic [7:0] period_hi_o,
  output logic [7:0] period_lo_o,
  output logic       period_valid_o
);
  localparam int PW = fpm_pkg::PAIR_W;

  logic             rise, tick, full;
  logic [CNT_W-1:0] lat;
  logic [PW-1:0]    pair;

  fpm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(vsync_i), .rise(rise));

  fpm_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(rise), .tick(tick));

  fpm_period_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(rise), .tick(tick),
    .lat_o(lat), .full_o(full));

  assign pair           = PW'(lat);
  assign period_hi_o    = pair[PW-1:fpm_pkg::BYTE_W];
  assign period_lo_o    = pair[fpm_pkg::BYTE_W-1:0];
  assign period_valid_o = vdet_i & full;

  // R6
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vdet_i |-> !period_valid_o);
  // R4
  hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {8'd0, period_hi_o} < (16'd1 << (CNT_W - fpm_pkg::BYTE_W)));
endmodule

// File: tb/sim_frame_period_meter.sv
module sim_frame_period_meter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync = 1'b0;
  logic vdet = 1'b0;
  logic [7:0] hi, lo;
  logic valid;

  int checks = 0, fails = 0, cyc = 0;
  int shown = 0, prev_n = -1, nedge = 0;
  string prev_tag = "R2";

  frame_period_meter u0 (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .vdet_i(vdet),
    .period_hi_o(hi), .period_lo_o(lo), .period_valid_o(valid));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int expect_of(input int n);
    int v = n / 16;
    return (v > 'h1FFF) ? 'h1FFF : v;
  endfunction

  // one frame: rising edge now, held high for w cycles, n cycles to next rise
  task automatic frame(input int n, input int w, input string tag);
    vsync = 1'b1;
    nedge++;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i == w) vsync = 1'b0;
      if (i == 2) chk("R3 hold", {hi[4:0], lo}, shown);
      if (i == 3) begin
        if (prev_n >= 0) begin
          shown = expect_of(prev_n);
          chk(prev_tag, {hi[4:0], lo}, shown);
        end else begin
          shown = {hi[4:0], lo};
        end
        chk("R4 pad", int'(hi[7:5]), 0);
        chk("R6 valid", int'(valid), (vdet && nedge >= 2) ? 1 : 0);
      end
    end
    prev_n = n;
    prev_tag = tag;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 hi", int'(hi), 0);
    chk("R1 lo", int'(lo), 0);
    chk("R1 valid", int'(valid), 0);
    rst_n = 1'b1;
    vdet = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_basic();
    frame(300, 4, "R2 first");
    frame(1600, 4, "R2 1600");
    frame(1607, 4, "R2 1607");
  endtask

  task automatic t_rounding();
    frame(1615, 4, "R2 floor 1615");
    frame(1616, 4, "R2 floor 1616");
    frame(17, 4, "R2 short");
  endtask

  task automatic t_fields();
    frame(16 * 'h123 + 5, 4, "R4 split 0x123");
    frame(16 * 'h0FF, 4, "R4 low only");
  endtask

  task automatic t_level();
    frame(400, 399, "R7 long high");
    frame(400, 1, "R7 one cycle");
  endtask

  task automatic t_vdet();
    vdet = 1'b0;
    frame(200, 4, "R6 vdet low");
    vdet = 1'b1;
    frame(200, 4, "R6 vdet back");
  endtask

  task automatic t_saturate();
    frame(132000, 4, "R5 saturate");
    frame(100, 4, "R2 after sat");
    frame(40, 4, "R2 tail");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_rounding();
    t_fields();
    t_level();
    t_vdet();
    t_saturate();
    vsync = 1'b1;
    repeat (3) @(negedge clk);
    chk(prev_tag, {hi[4:0], lo}, expect_of(prev_n));
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule